// File: doc/BRIEF.md
# Multiplexed Bus-Function Port

This block is an eight-pin bidirectional port. Every pin has an output latch bit, a direction bit and a pull-up enable bit, and all of them are written and read through a small register interface. Control bits from other blocks can hand any pin to an external-bus function. These functions are the upper address lines, the read and write strobes, a wait input, a bus-hold request and acknowledge pair, and a refresh request. Once a pin is handed over, its pad direction and level come from the bus controller and no longer from the port registers. The block drives each pad's output level, output enable and pull-up enable. It passes the wait and hold-request levels seen on pin 6 back to the bus controller.

A parameter selects a reduced variant. In that variant pins 0 to 3 are output-only, pins 4 and 5 are permanently the read and write strobes, and only pins 6 and 7 keep a programmable direction. Its reset levels also differ: pins 0 to 3 are high-impedance while reset is held and drive low afterwards, and pins 4 and 5 stay high during reset.

Top module: `busport_mux`

## Requirements
- R1: In the full variant, while reset is asserted and directly after it, every pad output enable is 0 and the direction and pull-up registers read 0.
- R2: With `regWe` high, the value is stored on the next clock edge: `regAddr` 0 writes the latch, 1 the direction (1 = output) and 2 the pull-up enables. A pin in output mode that is not taken over drives its latch bit with its output enable at 1.
- R3: A read at `regAddr` 0 returns the pad level for input-mode pins and the latch bit for output-mode pins. A read at 1 returns the direction and a read at 2 returns the pull-up enables.
- R4: A pad pull-up is on only when its enable bit is 1 and the pad output enable is 0. A pin that an alternate output function takes over has no pull-up.
- R5: `memMode` 0 leaves pins 0 to 3 to the port, and 1 enables bus expansion without upper address lines. 2 drives `busAddrHi[1:0]` on pins 0 and 1, and 3 drives `busAddrHi[3:0]` on pins 0 to 3, each with output enable 1.
- R6: Any nonzero `memMode` makes pins 4 and 5 drive `busRdN` and `busWrN` with output enable 1. At 0 they return to the port registers.
- R7: When `waitExt` or `holdEn` is set, pin 6 is forced to an input. `waitIn` equals the pin 6 pad level when `waitExt` is set or pin 6 is in input mode, and is 0 otherwise.
- R8: While `holdEn` is set, `holdReq` equals the pin 6 pad level and pin 7 drives `holdAck` as an output. `holdReq` is 0 otherwise.
- R9: While `refreshEn` is set and `holdEn` is clear, pin 7 drives `refreshReq` as an output. When both are set, the hold acknowledge wins.
- R10: In the reduced variant, pins 0 to 3 have output enable 0 during reset. After reset they drive their latch bits, which reset to 0, or the address lines. Direction bits 0 to 5 always read 1 and writes to them are ignored.
- R11: In the reduced variant, pins 4 and 5 are driven high during reset and carry `busRdN`/`busWrN` at all other times, whatever `memMode` is. Pull-up bits 0 to 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 latch/port, 1 direction, 2 pull-up |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output levels |
| padOe | output | 8 | Pad output enables |
| padPullup | output | 8 | Pad pull-up enables |
| memMode | input | 2 | Memory expansion mode |
| waitExt | input | 1 | External wait selected by the wait control |
| holdEn | input | 1 | Bus hold enabled |
| refreshEn | input | 1 | Refresh request output enabled |
| busAddrHi | input | 4 | Upper address lines from the bus controller |
| busRdN | input | 1 | Read strobe from the bus controller |
| busWrN | input | 1 | Write strobe from the bus controller |
| holdAck | input | 1 | Hold acknowledge from the bus controller |
| refreshReq | input | 1 | Refresh request from the refresh timer |
| waitIn | output | 1 | Wait level seen on pin 6 |
| holdReq | output | 1 | Hold request level seen on pin 6 |

## Verification
The hardest states to reach are the ones where several takeover sources meet on one pin. Examples are hold and refresh both claiming pin 7, or external wait forcing an output-mode pin 6 back to an input. Each such state only shows up when the register contents and the mode bits line up in a particular way. The stimulus first sets every pin to output with a known latch pattern. It then walks all 32 combinations of memory mode, wait, hold and refresh, so every pin that was not taken over still shows the latch value against each override. Both variants share the stimulus, and the reduced one is checked alongside the full one.

// File: rtl/busport_pkg.sv
package busport_pkg;
  localparam int PinCount = 8;

  typedef enum logic [1:0] {
    SelLatch = 2'd0,
    SelDir   = 2'd1,
    SelPull  = 2'd2,
    SelNone  = 2'd3
  } regSel_e;

  // per-pin takeover strobes from control to datapath
  typedef struct packed {
    logic [PinCount-1:0] ovrEn;
    logic [PinCount-1:0] ovrOe;
    logic [PinCount-1:0] ovrVal;
  } pinStrobe_t;
endpackage

// File: rtl/busport_ctrl.sv
module busport_ctrl
  import busport_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] memMode,
  input  logic       waitExt,
  input  logic       holdEn,
  input  logic       refreshEn,
  input  logic [3:0] busAddrHi,
  input  logic       busRdN,
  input  logic       busWrN,
  input  logic       holdAck,
  input  logic       refreshReq,
  input  logic       dir6,
  input  logic       pad6,
  output pinStrobe_t strb,
  output logic       waitIn,
  output logic       holdReq
);
  logic       expand;
  logic [3:0] addrPins;

  always_comb begin
    expand = (memMode != 2'd0);
    case (memMode)
      2'd2:    addrPins = 4'b0011;
      2'd3:    addrPins = 4'b1111;
      default: addrPins = 4'b0000;
    endcase
  end

  always_comb begin
    strb = '0;
    for (int i = 0; i < 4; i++) begin
      if (addrPins[i]) begin
        strb.ovrEn[i]  = 1'b1;
        strb.ovrOe[i]  = 1'b1;
        strb.ovrVal[i] = busAddrHi[i];
      end
    end
    if (expand || REDUCED) begin
      strb.ovrEn[5:4]  = 2'b11;
      strb.ovrOe[5:4]  = 2'b11;
      strb.ovrVal[5:4] = {busWrN, busRdN};
    end
    if (waitExt || holdEn) begin
      strb.ovrEn[6] = 1'b1;
      strb.ovrOe[6] = 1'b0;
    end
    if (holdEn) begin
      strb.ovrEn[7]  = 1'b1;
      strb.ovrOe[7]  = 1'b1;
      strb.ovrVal[7] = holdAck;
    end else if (refreshEn) begin
      strb.ovrEn[7]  = 1'b1;
      strb.ovrOe[7]  = 1'b1;
      strb.ovrVal[7] = refreshReq;
    end
  end

  assign waitIn  = (waitExt || !dir6) && pad6;
  assign holdReq = holdEn && pad6;

  assert_strobes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memMode != 2'd0) |-> (strb.ovrEn[5:4] == 2'b11 && strb.ovrOe[5:4] == 2'b11
                           && strb.ovrVal[5:4] == {busWrN, busRdN}));

  assert_wait_input_R7: assert property (@(posedge clk) disable iff (!rstN)
    waitExt |-> (strb.ovrEn[6] && !strb.ovrOe[6] && waitIn == pad6));

  assert_hold_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (holdEn && refreshEn) |-> (strb.ovrVal[7] == holdAck && holdReq == pad6));
endmodule

// File: rtl/busport_dp.sv
module busport_dp
  import busport_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [PinCount-1:0] regWdata,
  output logic [PinCount-1:0] regRdata,
  input  logic [PinCount-1:0] padIn,
  input  pinStrobe_t          strb,
  output logic [PinCount-1:0] padOut,
  output logic [PinCount-1:0] padOe,
  output logic [PinCount-1:0] padPullup,
  output logic                dir6
);
  localparam logic [PinCount-1:0] FixMask  = REDUCED ? 8'h3F : 8'h00;
  localparam logic [PinCount-1:0] PullMask = REDUCED ? 8'hF0 : 8'hFF;
  localparam logic [PinCount-1:0] RstOe    = REDUCED ? 8'h30 : 8'h00;
  localparam logic [PinCount-1:0] RstVal   = REDUCED ? 8'h30 : 8'h00;

  logic [PinCount-1:0] latchReg, dirReg, pullReg;
  regSel_e sel;

  assign sel = regSel_e'(regAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      dirReg   <= FixMask;
      pullReg  <= '0;
    end else if (regWe) begin
      case (sel)
        SelLatch: latchReg <= regWdata;
        SelDir:   dirReg   <= regWdata | FixMask;
        SelPull:  pullReg  <= regWdata & PullMask;
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < PinCount; i++) begin : g_pin
    assign padOe[i]     = !rstN ? RstOe[i]
                        : (strb.ovrEn[i] ? strb.ovrOe[i] : dirReg[i]);
    assign padOut[i]    = !rstN ? RstVal[i]
                        : (strb.ovrEn[i] ? strb.ovrVal[i] : latchReg[i]);
    assign padPullup[i] = pullReg[i] && !padOe[i];
  end

  always_comb begin
    case (sel)
      SelLatch: regRdata = (dirReg & latchReg) | (~dirReg & padIn);
      SelDir:   regRdata = dirReg;
      SelPull:  regRdata = pullReg;
      default:  regRdata = '0;
    endcase
  end

  assign dir6 = dirReg[6];

  always_comb begin
    if (!REDUCED && rstN === 1'b0)
      assert_reset_hiz_R1: assert (padOe == '0);
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd1) |=> (dirReg == ($past(regWdata) | FixMask)));

  assert_fixed_dir_R10: assert property (@(posedge clk) disable iff (!rstN)
    REDUCED |-> (dirReg[5:0] == 6'h3F && pullReg[3:0] == 4'h0));
endmodule

// File: rtl/busport_mux.sv
module busport_mux
  import busport_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic [7:0] padIn,
  output logic [7:0] padOut,
  output logic [7:0] padOe,
  output logic [7:0] padPullup,
  input  logic [1:0] memMode,
  input  logic       waitExt,
  input  logic       holdEn,
  input  logic       refreshEn,
  input  logic [3:0] busAddrHi,
  input  logic       busRdN,
  input  logic       busWrN,
  input  logic       holdAck,
  input  logic       refreshReq,
  output logic       waitIn,
  output logic       holdReq
);
  pinStrobe_t strb;
  logic       dir6;

  busport_ctrl #(.REDUCED(REDUCED)) u_ctrl (
    .clk(clk), .rstN(rstN), .memMode(memMode), .waitExt(waitExt),
    .holdEn(holdEn), .refreshEn(refreshEn), .busAddrHi(busAddrHi),
    .busRdN(busRdN), .busWrN(busWrN), .holdAck(holdAck),
    .refreshReq(refreshReq), .dir6(dir6), .pad6(padIn[6]),
    .strb(strb), .waitIn(waitIn), .holdReq(holdReq)
  );

  busport_dp #(.REDUCED(REDUCED)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn), .strb(strb),
    .padOut(padOut), .padOe(padOe), .padPullup(padPullup), .dir6(dir6)
  );
endmodule

// File: tb/busport_mux_test.sv
`timescale 1ns/1ps
module busport_mux_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] padIn = 8'hA5;
  logic [1:0] memMode = 2'd0;
  logic waitExt = 1'b0, holdEn = 1'b0, refreshEn = 1'b0;
  logic [3:0] busAddrHi = 4'h0;
  logic busRdN = 1'b1, busWrN = 1'b0, holdAck = 1'b0, refreshReq = 1'b0;

  logic [7:0] fRd, fOut, fOe, fPull, rRd, rOut, rOe, rPull;
  logic fWait, fHold, rWait, rHold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         sel;
    logic [7:0] mask;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  busport_mux #(.REDUCED(1'b0)) uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(fRd), .padIn(padIn), .padOut(fOut), .padOe(fOe), .padPullup(fPull),
    .memMode(memMode), .waitExt(waitExt), .holdEn(holdEn), .refreshEn(refreshEn),
    .busAddrHi(busAddrHi), .busRdN(busRdN), .busWrN(busWrN), .holdAck(holdAck),
    .refreshReq(refreshReq), .waitIn(fWait), .holdReq(fHold));

  busport_mux #(.REDUCED(1'b1)) uutRed (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(rRd), .padIn(padIn), .padOut(rOut), .padOe(rOe), .padPullup(rPull),
    .memMode(memMode), .waitExt(waitExt), .holdEn(holdEn), .refreshEn(refreshEn),
    .busAddrHi(busAddrHi), .busRdN(busRdN), .busWrN(busWrN), .holdAck(holdAck),
    .refreshReq(refreshReq), .waitIn(rWait), .holdReq(rHold));

  // sel: 0 oe, 1 out, 2 pull, 3 read, 4 wait, 5 hold; +10 for the reduced variant
  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return fOe;   1: return fOut;  2: return fPull;  3: return fRd;
      4: return {7'b0, fWait};          5: return {7'b0, fHold};
      10: return rOe;  11: return rOut; 12: return rPull; 13: return rRd;
      14: return {7'b0, rWait};         15: return {7'b0, rHold};
      default: return 8'h00;
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = observe(it.sel) & it.mask;
      checks++;
      if (act !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp & it.mask);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_item(int sel, logic [7:0] mask, logic [7:0] exp, string req);
    item_t it;
    it.sel = sel; it.mask = mask; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step();
    regWe = 1'b1; regAddr = a; regWdata = d;
    step();
    regWe = 1'b0; regAddr = 2'd0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step();
    // reset state, both variants
    expect_item(0, 8'hFF, 8'h00, "R1 reset oe");
    expect_item(10, 8'h0F, 8'h00, "R10 reset low pins hiz");
    expect_item(10, 8'h30, 8'h30, "R11 reset strobe oe");
    expect_item(11, 8'h30, 8'h30, "R11 reset strobes high");
    step();
    rstN = 1'b1;
    expect_item(0, 8'hFF, 8'h00, "R1 after reset oe");
    expect_item(3, 8'hFF, 8'hA5, "R3 read pads");
    expect_item(10, 8'hFF, 8'h3F, "R10 reduced oe");
    expect_item(11, 8'h3F, 8'h10, "R10 R11 reduced levels");
    step();
    regAddr = 2'd1;
    expect_item(3, 8'hFF, 8'h00, "R1 dir reset");
    expect_item(13, 8'hFF, 8'h3F, "R10 dir fixed");
    step();
    regAddr = 2'd2;
    expect_item(3, 8'hFF, 8'h00, "R1 pull reset");
    step();

    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h5A);
    wr(2'd2, 8'hFF);
    expect_item(0, 8'hFF, 8'h0F, "R2 oe from dir");
    expect_item(1, 8'h0F, 8'h0A, "R2 latch drive");
    expect_item(2, 8'hFF, 8'hF0, "R4 pull on inputs");
    expect_item(3, 8'hFF, 8'hAA, "R3 mixed read");
    expect_item(12, 8'hFF, 8'hC0, "R11 reduced pull pads");
    expect_item(13, 8'hFF, 8'h9A, "R10 reduced read");
    step();
    regAddr = 2'd2;
    expect_item(3, 8'hFF, 8'hFF, "R3 pull read");
    expect_item(13, 8'hFF, 8'hF0, "R11 pull bits");
    step();
    regAddr = 2'd1;
    expect_item(3, 8'hFF, 8'h0F, "R3 dir read");
    expect_item(13, 8'hFF, 8'h3F, "R10 dir write ignored");
    step();
    regAddr = 2'd0;

    memMode = 2'd2; busAddrHi = 4'h9;
    expect_item(1, 8'h3F, 8'h19, "R5 R6 mode2");
    expect_item(0, 8'hFF, 8'h3F, "R6 strobe oe");
    expect_item(2, 8'hFF, 8'hC0, "R4 no pull on strobes");
    step();
    memMode = 2'd3; busAddrHi = 4'h6;
    expect_item(1, 8'h0F, 8'h06, "R5 mode3");
    expect_item(11, 8'h0F, 8'h06, "R10 reduced address");
    step();
    memMode = 2'd1;
    expect_item(1, 8'h3F, 8'h1A, "R5 R6 mode1");
    step();
    memMode = 2'd0;
    expect_item(0, 8'hFF, 8'h0F, "R6 strobes released");
    expect_item(11, 8'h30, 8'h10, "R11 strobes always");
    step();

    padIn = 8'h40;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h40);
    expect_item(0, 8'hFF, 8'h40, "R2 pin6 output");
    expect_item(4, 8'h01, 8'h00, "R7 wait off");
    step();
    waitExt = 1'b1;
    expect_item(0, 8'h40, 8'h00, "R7 wait forces input");
    expect_item(4, 8'h01, 8'h01, "R7 wait ext");
    step();
    waitExt = 1'b0;
    wr(2'd1, 8'h00);
    expect_item(4, 8'h01, 8'h01, "R7 wait input mode");
    expect_item(5, 8'h01, 8'h00, "R8 hold off");
    step();

    wr(2'd1, 8'hC0);
    holdEn = 1'b1; holdAck = 1'b1; refreshEn = 1'b1; refreshReq = 1'b0;
    expect_item(5, 8'h01, 8'h01, "R8 hold req");
    expect_item(0, 8'hC0, 8'h80, "R8 hold pins");
    expect_item(1, 8'h80, 8'h80, "R8 hold ack");
    step();
    holdAck = 1'b0; refreshReq = 1'b1;
    expect_item(1, 8'h80, 8'h00, "R9 hold priority");
    step();
    holdEn = 1'b0;
    expect_item(1, 8'h80, 8'h80, "R9 refresh drive");
    expect_item(5, 8'h01, 8'h00, "R8 hold released");
    step();
    refreshEn = 1'b0;
    expect_item(1, 8'h80, 8'h00, "R9 refresh released");
    expect_item(0, 8'h80, 8'h80, "R9 oe from dir");
    step();

    // all mode combinations with every pin set to output
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFF);
    holdAck = 1'b0; refreshReq = 1'b0; busRdN = 1'b0; busWrN = 1'b0; busAddrHi = 4'h0;
    for (int c = 0; c < 32; c++) begin
      logic [7:0] eOe, eOut;
      memMode   = c[1:0];
      waitExt   = c[2];
      holdEn    = c[3];
      refreshEn = c[4];
      eOe = 8'hFF;
      if (c[2] || c[3]) eOe[6] = 1'b0;
      eOut[3:0] = (c[1:0] == 2'd3) ? 4'h0 : (c[1:0] == 2'd2) ? 4'hC : 4'hF;
      eOut[5:4] = (c[1:0] != 2'd0) ? 2'b00 : 2'b11;
      eOut[6]   = 1'b1;
      eOut[7]   = (c[3] || c[4]) ? 1'b0 : 1'b1;
      expect_item(0, 8'hFF, eOe, "R7 R8 R9 combo oe");
      expect_item(1, eOe, eOut, "R5 R6 R9 combo out");
      expect_item(4, 8'h01, {7'b0, c[2]}, "R7 combo wait");
      expect_item(5, 8'h01, {7'b0, c[3]}, "R8 combo hold");
      expect_item(11, 8'h3F, {2'b00, eOut[3:0]}, "R10 R11 combo reduced");
      step();
    end
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule